// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream or root port that supports hot-plug. Software reaches both registers through a 16-bit configuration write port with two byte enables; the current values are always visible on `ctl_o` and `sts_o`. The platform side feeds it device-insertion and attention-button events. It drives a level interrupt, a one-cycle message-interrupt request that carries a 5-bit vector, a strobe that asks the surrounding logic to remove the device, and a busy strobe that rejects an insertion.

Interrupts follow a single "notified" level: hot-plug interrupts are enabled and at least one supported status bit is set together with its enable bit. Only a change of that level produces a message or moves the level interrupt. Status bits clear by writing one. A control bit toggles the electromechanical interlock. Writing power-off with the power indicator off while a device is present removes the device. Every control write ends with a command-completed event. All state is registered, and every effect is visible one clock after the write or event that causes it.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Reset is synchronous and active low. Afterwards the control register reads attention indicator off (bits 7:6 = 11) with all enables clear. If `populated_i` is high, it reads power control on (bit 10 = 0) and power indicator on (bits 9:8 = 01); if low, it reads bit 10 = 1 and bits 9:8 = 11. The status register is clear except presence state (bit 6), which equals `populated_i`. Both interrupt outputs are low.
- R2: A control write (`cfg_sel_i` = 0) updates only the bytes whose enable is set. Only bits 0, 3, 4, 5 (hot-plug interrupt enable), 7:6, 9:8 and 10 hold a written value. Every other bit reads 0.
- R3: A control write with byte enable 1 set and bit 11 written as 1 inverts the interlock status bit (status bit 7). Control bit 11 always reads 0.
- R4: A status write (`cfg_sel_i` = 1, byte enable 0) clears each of status bits 0 (button pressed), 3 (presence changed) and 4 (command completed) that is written as 1. Bits 6 and 7 cannot be written.
- R5: When `insert_i` pulses while status bit 7 is 1, `busy_o` pulses and nothing changes. Otherwise status bit 6 is set and a combined event sets bits 3 and 0.
- R6: A pulse on `button_i` is an event on status bit 0.
- R7: An event whose status bits already include a set bit ORs its bits into the status register but raises no notification.
- R8: The notified level is: control bit 5 is set and (status AND control AND 0x0019) is nonzero. A notification is signalled only when this level differs from its stored value.
- R9: With `msg_en_i` high, a notification pulses `msg_req_o` for one cycle with `msg_vec_o` = `vector_i`, and `irq_o` holds. With `msg_en_i` low, `irq_o` takes the new notified level.
- R10: A status write recomputes and stores the notified level without signalling. If `msg_en_i` is low and the level is now 0, `irq_o` falls.
- R11: A control write whose merged value has bit 10 = 1 and bits 9:8 = 11, while status bit 6 is set, pulses `remove_o`, clears bit 6 and sets bit 3.
- R12: Every control write with any byte enable set raises a command-completed event (status bit 4), after removal and interlock processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| populated_i | input | 1 | Slot holds a device; sampled during reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects slot control, 1 selects slot status |
| cfg_wdata_i | input | 16 | Write data |
| cfg_be_i | input | 2 | Byte enables |
| insert_i | input | 1 | Device-inserted event pulse |
| button_i | input | 1 | Attention-button event pulse |
| msg_en_i | input | 1 | Message interrupts enabled |
| vector_i | input | 5 | Message vector, 0 to 31 |
| ctl_o | output | 16 | Slot control readback |
| sts_o | output | 16 | Slot status readback |
| irq_o | output | 1 | Level interrupt |
| msg_req_o | output | 1 | One-cycle message-interrupt request |
| msg_vec_o | output | 5 | Vector of the last message request |
| remove_o | output | 1 | One-cycle device-removal strobe |
| busy_o | output | 1 | One-cycle insertion-rejected strobe |

## Verification
Both registers appear on the ports every cycle, so a corrupted control or status bit shows on the cycle after the operation that wrote it. The stored notified level is not visible. If it is wrong, nothing shows until the next event, and then the event raises a message or level edge that should not occur, or fails to raise one that should. The random stream therefore mixes events, writes that clear status and changes of interrupt mode, so that a stale level is exposed within a few operations.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W   = 16;
    localparam int VEC_W   = 5;
    localparam int BE_W    = REG_W / 8;

    // control bit positions (enables share the status positions they gate)
    localparam int C_HPIE  = 5;
    localparam int C_AI_LO = 6;
    localparam int C_PI_LO = 8;
    localparam int C_PWR   = 10;
    localparam int C_EIL   = 11;
    // status bit positions
    localparam int S_BTN   = 0;
    localparam int S_PCHG  = 3;
    localparam int S_CC    = 4;
    localparam int S_PRES  = 6;
    localparam int S_EIS   = 7;

    localparam logic [1:0] IND_ON  = 2'b01;
    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] EV_MASK   = REG_W'((1 << S_BTN) | (1 << S_PCHG) | (1 << S_CC));
    localparam logic [REG_W-1:0] CTL_WMASK = REG_W'(16'h07F9);
    localparam logic [REG_W-1:0] EV_INS    = REG_W'((1 << S_PCHG) | (1 << S_BTN));
    localparam logic [REG_W-1:0] EV_BTN    = REG_W'(1 << S_BTN);
    localparam logic [REG_W-1:0] EV_CC     = REG_W'(1 << S_CC);

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] sts;
        logic             notified;
        logic             irq;
        logic             msg;
        logic [VEC_W-1:0] vec;
        logic             remove;
        logic             busy;
    } slot_st_t;

    function automatic logic notify_level(input logic [REG_W-1:0] ctl,
                                          input logic [REG_W-1:0] sts);
        return ctl[C_HPIE] && ((sts & ctl & EV_MASK) != '0);
    endfunction

    function automatic slot_st_t slot_reset(input logic populated);
        slot_st_t r;
        r = '0;
        r.ctl[C_AI_LO +: 2] = IND_OFF;
        r.ctl[C_PI_LO +: 2] = populated ? IND_ON : IND_OFF;
        r.ctl[C_PWR]        = ~populated;
        r.sts[S_PRES]       = populated;
        return r;
    endfunction
endpackage

// File: rtl/hp_bytemerge.sv
module hp_bytemerge #(
    parameter int W = 16,
    localparam int NB = W / 8
) (
    input  logic [W-1:0]  old_i,
    input  logic [W-1:0]  new_i,
    input  logic [NB-1:0] be_i,
    output logic [W-1:0]  merged_o
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
    end
endmodule

// File: rtl/hp_w1c_mask.sv
module hp_w1c_mask #(
    parameter int W = 16,
    parameter logic [W-1:0] MASK = '0,
    localparam int NB = W / 8
) (
    input  logic [W-1:0]  wdata_i,
    input  logic [NB-1:0] be_i,
    output logic [W-1:0]  clr_o
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign clr_o[8*b +: 8] = be_i[b] ? (wdata_i[8*b +: 8] & MASK[8*b +: 8]) : 8'h00;
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             populated_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_sel_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    input  logic [BE_W-1:0]  cfg_be_i,
    input  logic             insert_i,
    input  logic             button_i,
    input  logic             msg_en_i,
    input  logic [VEC_W-1:0] vector_i,
    output logic [REG_W-1:0] ctl_o,
    output logic [REG_W-1:0] sts_o,
    output logic             irq_o,
    output logic             msg_req_o,
    output logic [VEC_W-1:0] msg_vec_o,
    output logic             remove_o,
    output logic             busy_o
);
    slot_st_t q, d;

    logic             ctl_wr, sts_wr;
    logic [REG_W-1:0] ctl_merged, ctl_next, sts_clr;
    logic             notify_req, lvl;

    assign ctl_wr = cfg_wr_i && !cfg_sel_i && (cfg_be_i != '0);
    assign sts_wr = cfg_wr_i &&  cfg_sel_i && (cfg_be_i != '0);

    hp_bytemerge #(.W(REG_W)) u_merge (
        .old_i    (q.ctl),
        .new_i    (cfg_wdata_i),
        .be_i     (cfg_be_i),
        .merged_o (ctl_merged)
    );

    hp_w1c_mask #(.W(REG_W), .MASK(EV_MASK)) u_w1c (
        .wdata_i (cfg_wdata_i),
        .be_i    (cfg_be_i),
        .clr_o   (sts_clr)
    );

    assign ctl_next = ctl_merged & CTL_WMASK;

    always_comb begin
        d          = q;
        d.msg      = 1'b0;
        d.remove   = 1'b0;
        d.busy     = 1'b0;
        notify_req = 1'b0;

        // slot control write: interlock toggle, removal, then command completed
        if (ctl_wr) begin
            d.ctl = ctl_next;
            if (cfg_be_i[C_EIL / 8] && cfg_wdata_i[C_EIL]) begin
                d.sts[S_EIS] = ~q.sts[S_EIS];
            end
            if (q.sts[S_PRES] && ctl_next[C_PWR] &&
                (ctl_next[C_PI_LO +: 2] == IND_OFF)) begin
                d.remove       = 1'b1;
                d.sts[S_PRES]  = 1'b0;
                d.sts[S_PCHG]  = 1'b1;
            end
            notify_req = 1'b1;
            d.sts      = d.sts | EV_CC;
        end

        // slot status write: clear supported events
        if (sts_wr) begin
            d.sts = d.sts & ~sts_clr;
        end

        // device insertion
        if (insert_i) begin
            if (d.sts[S_EIS]) begin
                d.busy = 1'b1;
            end else begin
                d.sts[S_PRES] = 1'b1;
                if ((d.sts & EV_INS) == '0) begin
                    notify_req = 1'b1;
                end
                d.sts = d.sts | EV_INS;
            end
        end

        // attention button
        if (button_i) begin
            if ((d.sts & EV_BTN) == '0) begin
                notify_req = 1'b1;
            end
            d.sts = d.sts | EV_BTN;
        end

        lvl = notify_level(d.ctl, d.sts);

        if (notify_req && (lvl != q.notified)) begin
            d.notified = lvl;
            if (msg_en_i) begin
                d.msg = 1'b1;
                d.vec = vector_i;
            end else begin
                d.irq = lvl;
            end
        end else if (sts_wr) begin
            d.notified = lvl;
            if (!msg_en_i && !lvl) begin
                d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= slot_reset(populated_i);
        end else begin
            q <= d;
        end
    end

    assign ctl_o     = q.ctl;
    assign sts_o     = q.sts;
    assign irq_o     = q.irq;
    assign msg_req_o = q.msg;
    assign msg_vec_o = q.vec;
    assign remove_o  = q.remove;
    assign busy_o    = q.busy;
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
    import hp_slot_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_i,
    input logic             cfg_sel_i,
    input logic [REG_W-1:0] cfg_wdata_i,
    input logic [BE_W-1:0]  cfg_be_i,
    input logic             insert_i,
    input logic             msg_en_i,
    input logic [REG_W-1:0] sts_o,
    input logic             irq_o,
    input logic             msg_req_o,
    input logic             remove_o,
    input logic             busy_o
);
    assert_cc_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr_i && !cfg_sel_i && (cfg_be_i != '0))) |-> sts_o[S_CC]);

    assert_interlock_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr_i && !cfg_sel_i && cfg_be_i[C_EIL / 8] && cfg_wdata_i[C_EIL]))
        |-> (sts_o[S_EIS] != $past(sts_o[S_EIS])));

    assert_busy_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($past(sts_o[S_EIS]) && $stable(sts_o[S_PRES])));

    assert_removal_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        remove_o |-> (!sts_o[S_PRES] && sts_o[S_PCHG] && $past(sts_o[S_PRES])));

    assert_msg_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req_o |-> ($past(msg_en_i) && $stable(irq_o)));

    assert_presence_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr_i && cfg_sel_i && !insert_i))
        |-> (sts_o[S_PRES] == $past(sts_o[S_PRES])));
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_be_i    (cfg_be_i),
    .insert_i    (insert_i),
    .msg_en_i    (msg_en_i),
    .sts_o       (sts_o),
    .irq_o       (irq_o),
    .msg_req_o   (msg_req_o),
    .remove_o    (remove_o),
    .busy_o      (busy_o)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        populated = 1'b1;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_be = '0;
    logic        insert = 1'b0, button = 1'b0, msg_en = 1'b0;
    logic [4:0]  vector = '0;
    logic [15:0] ctl, sts;
    logic        irq, msg_req, remove, busy;
    logic [4:0]  msg_vec;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_ctl, m_sts;
    logic        m_not, m_irq, e_msg, e_rem, e_busy;
    logic [4:0]  e_vec;

    always #5 clk = ~clk;

    hp_slot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .populated_i(populated),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_be_i(cfg_be),
        .insert_i(insert), .button_i(button), .msg_en_i(msg_en), .vector_i(vector),
        .ctl_o(ctl), .sts_o(sts), .irq_o(irq), .msg_req_o(msg_req), .msg_vec_o(msg_vec),
        .remove_o(remove), .busy_o(busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic level(input logic [15:0] c, input logic [15:0] s);
        return c[5] && ((s & c & 16'h0019) != 16'h0);
    endfunction

    task automatic model_reset(input logic pop);
        m_ctl = pop ? 16'h01C0 : 16'h07C0;
        m_sts = pop ? 16'h0040 : 16'h0000;
        m_not = 0; m_irq = 0; e_msg = 0; e_rem = 0; e_busy = 0; e_vec = '0;
    endtask

    // kind: 0 idle, 1 control write, 2 status write, 3 insert, 4 button
    task automatic model_step(input int kind, input logic [15:0] wd, input logic [1:0] be);
        logic notify, stsw, lv;
        logic [15:0] nc;
        notify = 0; stsw = 0; e_msg = 0; e_rem = 0; e_busy = 0;
        if (kind == 1 && be != 2'b00) begin
            nc = m_ctl;
            if (be[0]) nc[7:0] = wd[7:0];
            if (be[1]) nc[15:8] = wd[15:8];
            nc &= 16'h07F9;
            if (be[1] && wd[11]) m_sts[7] = ~m_sts[7];
            if (m_sts[6] && nc[10] && nc[9:8] == 2'b11) begin
                e_rem = 1; m_sts[6] = 0; m_sts[3] = 1;
            end
            m_ctl = nc;
            notify = 1;
            m_sts[4] = 1;
        end else if (kind == 2 && be != 2'b00) begin
            if (be[0]) m_sts = m_sts & ~(wd & 16'h0019);
            stsw = 1;
        end else if (kind == 3) begin
            if (m_sts[7]) e_busy = 1;
            else begin
                m_sts[6] = 1;
                if ((m_sts & 16'h0009) == 16'h0) notify = 1;
                m_sts = m_sts | 16'h0009;
            end
        end else if (kind == 4) begin
            if (!m_sts[0]) notify = 1;
            m_sts[0] = 1;
        end
        lv = level(m_ctl, m_sts);
        if (notify && lv != m_not) begin
            m_not = lv;
            if (msg_en) begin e_msg = 1; e_vec = vector; end
            else m_irq = lv;
        end else if (stsw) begin
            m_not = lv;
            if (!msg_en && !lv) m_irq = 0;
        end
    endtask

    task automatic compare_all();
        chk("R2 ctl", ctl, m_ctl);
        chk("R4 sts", sts, m_sts);
        chk("R9 irq", {15'd0, irq}, {15'd0, m_irq});
        chk("R8 msg_req", {15'd0, msg_req}, {15'd0, e_msg});
        chk("R11 remove", {15'd0, remove}, {15'd0, e_rem});
        chk("R5 busy", {15'd0, busy}, {15'd0, e_busy});
        if (e_msg) chk("R9 vector", {11'd0, msg_vec}, {11'd0, e_vec});
    endtask

    task automatic op(input int kind, input logic [15:0] wd, input logic [1:0] be);
        @(negedge clk);
        cfg_wr = (kind == 1 || kind == 2);
        cfg_sel = (kind == 2);
        cfg_wdata = wd;
        cfg_be = be;
        insert = (kind == 3);
        button = (kind == 4);
        model_step(kind, wd, be);
        @(posedge clk);
        #1;
        cfg_wr = 0; insert = 0; button = 0;
        compare_all();
    endtask

    task automatic do_reset(input logic pop);
        @(negedge clk);
        rst_n = 0; populated = pop;
        @(posedge clk); @(posedge clk);
        #1;
        model_reset(pop);
        rst_n = 1;
        chk("R1 reset ctl", ctl, m_ctl);
        chk("R1 reset sts", sts, m_sts);
        chk("R1 reset irq", {15'd0, irq}, 16'd0);
        chk("R1 reset msg", {15'd0, msg_req}, 16'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R1: empty slot reset
        do_reset(1'b0);
        // R1: populated slot reset
        do_reset(1'b1);

        // R3: interlock toggle through high byte, control bit 11 reads 0
        op(1, 16'h0800, 2'b10);
        chk("R3 eis set", {15'd0, sts[7]}, 16'd1);
        chk("R3 ctl bit11 zero", {15'd0, ctl[11]}, 16'd0);
        // R12: command completed raised by that write
        chk("R12 cc", {15'd0, sts[4]}, 16'd1);
        // R5: insertion rejected while locked
        op(3, 16'h0, 2'b00);
        chk("R5 busy pulse", {15'd0, busy}, 16'd1);
        op(1, 16'h0800, 2'b10);               // R3 unlock
        op(2, 16'h0019, 2'b01);               // R4 clear all events
        // R8: enable hot-plug interrupt + button enable, level stays low
        op(1, 16'h0121, 2'b11);
        chk("R8 no irq yet", {15'd0, irq}, 16'd0);
        op(4, 16'h0, 2'b00);                  // R6 button -> level high
        chk("R9 irq high", {15'd0, irq}, 16'd1);
        op(4, 16'h0, 2'b00);                  // R7 repeated event
        chk("R7 no change", {15'd0, irq}, 16'd1);
        op(2, 16'h0001, 2'b01);               // R10 clear drops irq
        chk("R10 irq low", {15'd0, irq}, 16'd0);
        // R9: message mode
        msg_en = 1; vector = 5'd31;
        op(4, 16'h0, 2'b00);
        chk("R9 msg pulse", {15'd0, msg_req}, 16'd1);
        op(0, 16'h0, 2'b00);
        chk("R9 msg one cycle", {15'd0, msg_req}, 16'd0);
        msg_en = 0;
        // R11: power off + indicator off while present
        op(1, 16'h0721, 2'b11);
        chk("R11 remove", {15'd0, remove}, 16'd1);
        chk("R11 presence cleared", {15'd0, sts[6]}, 16'd0);
        // R5: insertion when unlocked
        op(3, 16'h0, 2'b00);
        chk("R5 presence set", {15'd0, sts[6]}, 16'd1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            int kind;
            logic [15:0] wd;
            logic [1:0] be;
            r = $urandom_range(0, 99);
            kind = (r < 10) ? 0 : (r < 40) ? 1 : (r < 65) ? 2 : (r < 80) ? 3 : 4;
            wd = 16'($urandom);
            if ($urandom_range(0, 3) == 0) wd[11] = 1'b0;
            if (kind == 1 && $urandom_range(0, 2) == 0) wd[10:8] = 3'b111;
            be = 2'($urandom);
            vector = 5'($urandom);
            if (kind == 0 && $urandom_range(0, 1) == 0) msg_en = ~msg_en;
            if ($urandom_range(0, 499) == 0) do_reset(1'($urandom));
            else op(kind, wd, be);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule